// File: doc/BRIEF.md
# Stack Push/Pop Execution Unit

This unit carries out single-byte stack instructions against an external 32-bit register file of eight entries and a byte-addressed data memory. A push opcode lowers the stack pointer by one word and stores the selected register at the new pointer. A pop opcode loads the word at the current pointer into the selected register and then raises the pointer by one word. The register number is taken from the low three bits of the opcode. Register 4 is the stack pointer.

A caller presents an opcode with a one-cycle `start` strobe. The unit samples the selected register and the stack pointer in that cycle. It then issues one word-wide memory request and holds it until `ready` returns. In the cycle after the transfer it drives the register-file write ports and pulses `done`. An opcode outside the push and pop groups causes a one-cycle `done` with `err`. Such an opcode touches neither memory nor registers.

The controller has four states. `ST_IDLE` waits for `start`. `ST_ACCESS` holds the memory request. `ST_FINISH` performs the register writes and signals completion. `ST_FAULT` reports a rejected opcode. The transitions are:

- `ST_IDLE` goes to `ST_ACCESS` on start with a valid opcode.
- `ST_IDLE` goes to `ST_FAULT` on start with an invalid opcode.
- `ST_ACCESS` stays in `ST_ACCESS` while `mem_ready` is low.
- `ST_ACCESS` goes to `ST_FINISH` when `mem_ready` is high.
- `ST_FINISH` and `ST_FAULT` both return to `ST_IDLE` unconditionally.

Top module: `stack_pushpop_unit`

## Requirements
- R1: Opcodes 0x50 through 0x57 are pushes and opcodes 0x58 through 0x5F are pops. The register index is opcode bits [2:0], and index 4 names the stack pointer.
- R2: A push writes the register value, as sampled at start, to address SP-4 and then sets SP to SP-4. For example, SP 0x64 with 0x0a in register 3 gives SP 0x60 and 0x0a stored at 0x60.
- R3: A pop reads the word at address SP, writes it to the selected register and sets SP to SP+4.
- R4: Words are little-endian. Byte lane k (bits [8k+7:8k] of `mem_wdata` and `mem_rdata`) maps to address `mem_addr`+k, so the bytes 0a 00 00 00 at 0x60 pop as 0x0000000a.
- R5: Each instruction makes exactly one memory request, and that request has all four byte enables set.
- R6: While the request waits for `mem_ready`, the address, write enable and write data stay stable, and no register write or `done` occurs. A valid instruction completes `done` two cycles after start plus one cycle per wait cycle.
- R7: Pushing the stack pointer (0x54) stores its value from before the decrement.
- R8: Popping into the stack pointer (0x5C) leaves the loaded word in it, not the incremented pointer.
- R9: Any opcode outside 0x50 through 0x5F pulses `err` with `done` one cycle after start. It makes no memory request and no register write.
- R10: `done` is a one-cycle pulse. All register writes of an instruction take effect at the clock edge that ends the `done` cycle.
- R11: `start` and `opcode` are ignored while an instruction is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (sampled in idle only) |
| opcode | input | 8 | Instruction byte |
| rf_rd_idx | output | 3 | Register read index (low opcode bits) |
| rf_rd_data | input | 32 | Value of register `rf_rd_idx` |
| rf_sp_data | input | 32 | Current stack pointer value |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | 3 | Register write index |
| rf_wdata | output | 32 | Register write data |
| sp_we | output | 1 | Stack pointer write enable |
| sp_wdata | output | 32 | New stack pointer value |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_be | output | 4 | Byte lane enables |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_rdata | input | 32 | Read data, little-endian lanes |
| mem_ready | input | 1 | Memory completes the request this cycle |
| done | output | 1 | Instruction finished (one-cycle pulse) |
| err | output | 1 | Opcode rejected (with `done`) |

## Verification
A pop into the stack pointer has two updates aimed at register 4 in the same completion cycle: the loaded word and the raised pointer. The bench provokes this with opcode 0x5C over a prepared memory word and judges it by the final register value. It also sends 0x5C at the end of a push/pop sweep over every register, in which the popped word was just pushed. A second collision is a new `start` arriving while an instruction is still waiting on memory. The bench holds `start` high with a different valid opcode through a slow transfer. It then judges from the full register and memory image that exactly one instruction took effect.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int XLEN       = 32;
    localparam int RIDX_W     = 3;
    localparam int OPC_W      = 8;
    localparam int SP_INDEX   = 4;
    localparam int WORD_BYTES = XLEN / 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_FINISH,
        ST_FAULT
    } stk_state_e;

    typedef enum logic [1:0] {
        K_PUSH,
        K_POP,
        K_BAD
    } stk_kind_e;
endpackage

// File: rtl/stk_decode.sv
module stk_decode
    import stk_pkg::*;
#(
    parameter int               OPC_W     = 8,
    parameter int               RIDX_W    = 3,
    parameter logic [OPC_W-1:0] PUSH_BASE = 8'h50,
    parameter logic [OPC_W-1:0] POP_BASE  = 8'h58
) (
    input  logic [OPC_W-1:0]  opcode,
    output stk_kind_e         kind,
    output logic [RIDX_W-1:0] ridx
);
    localparam int GRP_W = OPC_W - RIDX_W;

    logic [GRP_W-1:0] group;

    assign group = opcode[OPC_W-1:RIDX_W];
    assign ridx  = opcode[RIDX_W-1:0];

    always_comb begin
        if (group == PUSH_BASE[OPC_W-1:RIDX_W]) begin
            kind = K_PUSH;
        end else if (group == POP_BASE[OPC_W-1:RIDX_W]) begin
            kind = K_POP;
        end else begin
            kind = K_BAD;
        end
    end
endmodule

// File: rtl/stk_addr.sv
module stk_addr #(
    parameter int XLEN = 32,
    parameter int STEP = 4
) (
    input  logic [XLEN-1:0] sp,
    input  logic            is_push,
    output logic [XLEN-1:0] acc_addr,
    output logic [XLEN-1:0] sp_next
);
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    logic [XLEN-1:0] sp_dec;
    logic [XLEN-1:0] sp_inc;

    assign sp_dec = sp - STEP_V;
    assign sp_inc = sp + STEP_V;

    // push: pre-decrement, access at the new pointer
    // pop:  access at the current pointer, post-increment
    assign acc_addr = is_push ? sp_dec : sp;
    assign sp_next  = is_push ? sp_dec : sp_inc;
endmodule

// File: rtl/stack_pushpop_unit.sv
module stack_pushpop_unit
    import stk_pkg::*;
#(
    parameter int XLEN     = stk_pkg::XLEN,
    parameter int RIDX_W   = stk_pkg::RIDX_W,
    parameter int OPC_W    = stk_pkg::OPC_W,
    parameter int SP_INDEX = stk_pkg::SP_INDEX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OPC_W-1:0]  opcode,
    output logic [RIDX_W-1:0] rf_rd_idx,
    input  logic [XLEN-1:0]   rf_rd_data,
    input  logic [XLEN-1:0]   rf_sp_data,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_widx,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              sp_we,
    output logic [XLEN-1:0]   sp_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN/8-1:0] mem_be,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              mem_ready,
    output logic              done,
    output logic              err
);
    localparam int                BYTES  = XLEN / 8;
    localparam logic [RIDX_W-1:0] SP_IDX = RIDX_W'(SP_INDEX);

    stk_state_e        state_q, state_d;
    stk_kind_e         dec_kind;
    logic [RIDX_W-1:0] dec_idx;
    stk_kind_e         kind_q;
    logic [RIDX_W-1:0] idx_q;
    logic [XLEN-1:0]   val_q;
    logic [XLEN-1:0]   sp_q;
    logic [XLEN-1:0]   load_q;
    logic [XLEN-1:0]   acc_addr;
    logic [XLEN-1:0]   sp_next;
    logic              is_push_q;
    logic              accept;

    stk_decode #(
        .OPC_W (OPC_W),
        .RIDX_W(RIDX_W)
    ) u_decode (
        .opcode(opcode),
        .kind  (dec_kind),
        .ridx  (dec_idx)
    );

    assign is_push_q = (kind_q == K_PUSH);

    stk_addr #(
        .XLEN(XLEN),
        .STEP(BYTES)
    ) u_addr (
        .sp      (sp_q),
        .is_push (is_push_q),
        .acc_addr(acc_addr),
        .sp_next (sp_next)
    );

    assign rf_rd_idx = dec_idx;
    assign accept    = (state_q == ST_IDLE) && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (dec_kind == K_BAD) ? ST_FAULT : ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (mem_ready) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // operand capture at start, load capture at transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= K_BAD;
            idx_q  <= '0;
            val_q  <= '0;
            sp_q   <= '0;
            load_q <= '0;
        end else begin
            if (accept) begin
                kind_q <= dec_kind;
                idx_q  <= dec_idx;
                val_q  <= rf_rd_data;
                sp_q   <= rf_sp_data;
            end
            if ((state_q == ST_ACCESS) && mem_ready && !is_push_q) begin
                load_q <= mem_rdata;
            end
        end
    end

    // outputs per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_be    = '0;
        mem_addr  = '0;
        mem_wdata = '0;
        rf_we     = 1'b0;
        rf_widx   = '0;
        rf_wdata  = '0;
        sp_we     = 1'b0;
        sp_wdata  = '0;
        done      = 1'b0;
        err       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ACCESS: begin
                mem_req   = 1'b1;
                mem_we    = is_push_q;
                mem_be    = '1;
                mem_addr  = acc_addr;
                mem_wdata = is_push_q ? val_q : '0;
            end
            ST_FINISH: begin
                done     = 1'b1;
                sp_wdata = sp_next;
                if (is_push_q) begin
                    sp_we = 1'b1;
                end else begin
                    rf_we    = 1'b1;
                    rf_widx  = idx_q;
                    rf_wdata = load_q;
                    sp_we    = (idx_q != SP_IDX);
                end
            end
            ST_FAULT: begin
                done = 1'b1;
                err  = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // R5
    be_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be == '1));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata)));

    // R6
    no_write_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (!rf_we && !sp_we && !done));

    // R2
    push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready) |=> (sp_we && done
                                              && (sp_wdata == $past(mem_addr))));

    // R3
    pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> (done && rf_we
            && (!sp_we || (sp_wdata == $past(mem_addr) + XLEN'(BYTES)))));

    // R8
    sp_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && (rf_widx == SP_IDX)) |-> !sp_we);

    // R9
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !rf_we && !sp_we && !mem_req));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/tb_stack_pushpop_unit.sv
module tb_stack_pushpop_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [7:0]  opcode;
    logic [2:0]  rf_rd_idx;
    logic [31:0] rf_rd_data;
    logic [31:0] rf_sp_data;
    logic        rf_we;
    logic [2:0]  rf_widx;
    logic [31:0] rf_wdata;
    logic        sp_we;
    logic [31:0] sp_wdata;
    logic        mem_req;
    logic        mem_we;
    logic [3:0]  mem_be;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ready;
    logic        done;
    logic        err;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_pushpop_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_sp_data(rf_sp_data),
        .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
        .sp_we(sp_we), .sp_wdata(sp_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .done(done), .err(err)
    );

    // bench-side register file and memory
    logic [31:0] rf [8];
    logic [7:0]  mem [256];
    logic        ld_rf_en;
    logic [2:0]  ld_idx;
    logic [31:0] ld_val;
    logic        ld_mem_en;
    logic [7:0]  ld_ma;
    logic [7:0]  ld_mb;
    int          lat;
    int          wcnt;

    assign rf_rd_data = rf[rf_rd_idx];
    assign rf_sp_data = rf[4];
    assign mem_rdata  = {mem[8'(mem_addr[7:0] + 8'd3)], mem[8'(mem_addr[7:0] + 8'd2)],
                         mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
    assign mem_ready  = mem_req && (wcnt == lat);

    always @(posedge clk) begin
        if (ld_rf_en) rf[ld_idx] <= ld_val;
        if (ld_mem_en) mem[ld_ma] <= ld_mb;
        if (rf_we) rf[rf_widx] <= rf_wdata;
        if (sp_we) rf[4] <= sp_wdata;
        if (mem_req && mem_we && mem_ready) begin
            for (int k = 0; k < 4; k++) begin
                mem[8'(mem_addr[7:0] + 8'(k))] <= mem_wdata[8*k +: 8];
            end
        end
        if (mem_req && !mem_ready) wcnt <= wcnt + 1;
        else wcnt <= 0;
    end

    logic [31:0] exp_rf [8];
    logic [7:0]  exp_mem [256];
    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_reg(input int i, input logic [31:0] v);
        ld_idx = 3'(i); ld_val = v; ld_rf_en = 1'b1;
        @(negedge clk);
        ld_rf_en = 1'b0;
        exp_rf[i] = v;
    endtask

    task automatic set_byte(input int a, input logic [7:0] b);
        ld_ma = 8'(a); ld_mb = b; ld_mem_en = 1'b1;
        @(negedge clk);
        ld_mem_en = 1'b0;
        exp_mem[a] = b;
    endtask

    // expected effect of one opcode, computed from R1-style rules
    task automatic apply(input logic [7:0] op);
        int          idx;
        logic [31:0] sp;
        logic [31:0] v;
        idx = int'(op[2:0]);
        sp  = exp_rf[4];
        if (op[7:3] == 5'b01010) begin
            v = exp_rf[idx];
            sp = sp - 32'd4;
            for (int k = 0; k < 4; k++) exp_mem[8'(sp[7:0] + 8'(k))] = v[8*k +: 8];
            exp_rf[4] = sp;
        end else if (op[7:3] == 5'b01011) begin
            for (int k = 0; k < 4; k++) v[8*k +: 8] = exp_mem[8'(sp[7:0] + 8'(k))];
            exp_rf[4] = sp + 32'd4;
            exp_rf[idx] = v;
        end
    endtask

    task automatic cmp_all(input string req);
        bit ok;
        logic [31:0] a, e;
        ok = 1'b1; a = '0; e = '0;
        for (int i = 0; i < 8; i++) begin
            if (ok && (rf[i] !== exp_rf[i])) begin
                ok = 1'b0; a = rf[i]; e = exp_rf[i];
            end
        end
        for (int i = 0; i < 256; i++) begin
            if (ok && (mem[i] !== exp_mem[i])) begin
                ok = 1'b0; a = {24'(i), mem[i]}; e = {24'(i), exp_mem[i]};
            end
        end
        chk(ok, req, a, e);
    endtask

    // runs one instruction; called and returns at a negedge, after writes landed
    task automatic run_op(input logic [7:0] op, input int l, input bit spam,
                          output int cycles, output bit e, output int reqs,
                          output logic [31:0] sp_at_done);
        int n;
        lat = l; opcode = op; start = 1'b1;
        reqs = 0;
        @(negedge clk);
        if (spam) opcode = 8'h5C;
        else start = 1'b0;
        n = 1;
        while (!done && n < 40) begin
            if (mem_req) reqs++;
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        if (n >= 40) chk(1'b0, "R6 timeout", 32'(n), 32'd0);
        cycles = n; e = err; sp_at_done = rf[4];
        @(negedge clk);
        chk(!done, "R10 done pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic run_valid(input logic [7:0] op, input int l, input bit spam,
                             input string req);
        int cyc, rq;
        bit e;
        logic [31:0] spd, sp_old;
        sp_old = exp_rf[4];
        run_op(op, l, spam, cyc, e, rq, spd);
        apply(op);
        chk(cyc == l + 2, "R6 latency", 32'(cyc), 32'(l + 2));
        chk(rq == l + 1 && !e, "R5 single request", 32'(rq), 32'(l + 1));
        chk(spd === sp_old, "R10 write at done edge", spd, sp_old);
        cmp_all(req);
    endtask

    initial begin
        begin : watchdog
            #(CLK_PERIOD * 150000);
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; opcode = 8'h00; lat = 0;
        ld_rf_en = 1'b0; ld_mem_en = 1'b0; ld_idx = '0; ld_val = '0; ld_ma = '0; ld_mb = '0;
        repeat (3) @(negedge clk);
        chk(!done && !err && !mem_req && !rf_we && !sp_we, "reset outputs",
            {27'd0, done, err, mem_req, rf_we, sp_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_req, "reset idle", {30'd0, done, mem_req}, 32'd0);

        for (int i = 0; i < 256; i++) set_byte(i, 8'h00);
        for (int i = 0; i < 8; i++) set_reg(i, 32'h0);

        // R2 R4: worked example
        set_reg(4, 32'h64); set_reg(3, 32'h0a);
        run_valid(8'h53, 1, 1'b0, "R2 push example");
        chk({mem[8'h63], mem[8'h62], mem[8'h61], mem[8'h60]} === 32'h0000000a,
            "R4 push bytes", {mem[8'h63], mem[8'h62], mem[8'h61], mem[8'h60]}, 32'h0a);
        chk(rf[4] === 32'h60, "R2 sp after push", rf[4], 32'h60);

        // R3 R4: pop example
        set_reg(3, 32'h0); set_reg(4, 32'h60);
        set_byte(8'h60, 8'h0a); set_byte(8'h61, 8'h00);
        set_byte(8'h62, 8'h00); set_byte(8'h63, 8'h00);
        run_valid(8'h5B, 0, 1'b0, "R3 pop example");
        chk(rf[3] === 32'h0000000a, "R4 pop value", rf[3], 32'h0a);
        chk(rf[4] === 32'h64, "R3 sp after pop", rf[4], 32'h64);

        // R1 R6: sweep of every register, push then pop, with memory latency 0..3
        for (int l = 0; l < 4; l++) begin
            for (int r = 0; r < 8; r++) begin
                for (int i = 0; i < 8; i++)
                    set_reg(i, (i == 4) ? 32'h80 : (32'h01020304 * (i + 1)) ^ {8'(l), 8'(r), 16'h5a3c});
                run_valid(8'h50 | 8'(r), l, 1'b0, "R1 push sweep");
                run_valid(8'h58 | 8'((r + 5) % 8), l, 1'b0, "R1 pop sweep");
            end
        end

        // R7: push of the stack pointer stores its old value
        set_reg(4, 32'h40);
        run_valid(8'h54, 2, 1'b0, "R7 push sp");
        chk({mem[8'h3F], mem[8'h3E], mem[8'h3D], mem[8'h3C]} === 32'h40, "R7 stored old sp",
            {mem[8'h3F], mem[8'h3E], mem[8'h3D], mem[8'h3C]}, 32'h40);

        // R8: pop into the stack pointer keeps the loaded word
        set_reg(4, 32'h40);
        set_byte(8'h40, 8'h44); set_byte(8'h41, 8'h33);
        set_byte(8'h42, 8'h22); set_byte(8'h43, 8'h11);
        run_valid(8'h5C, 1, 1'b0, "R8 pop sp");
        chk(rf[4] === 32'h11223344, "R8 sp loaded", rf[4], 32'h11223344);

        // R11: start held with another opcode during a slow transfer
        set_reg(4, 32'h90); set_reg(1, 32'hdeadbeef);
        run_valid(8'h51, 3, 1'b1, "R11 start ignored while busy");

        // R9: every opcode outside the push/pop groups
        set_reg(4, 32'h70);
        for (int op = 0; op < 256; op++) begin
            if (op[7:4] != 4'h5) begin
                int cyc, rq;
                bit e;
                logic [31:0] spd;
                run_op(8'(op), 0, 1'b0, cyc, e, rq, spd);
                chk(e && cyc == 1 && rq == 0, "R9 invalid opcode", {8'(op), 8'(cyc), 8'(rq), 7'd0, e},
                    {8'(op), 8'd1, 8'd0, 8'd1});
                cmp_all("R9 no state change");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule